// File: doc/BRIEF.md
# Memory Protection Entry File with Switchable Register Width

This block stores up to sixteen memory-protection entries and decides, for every access a core makes, whether that access may proceed. Each entry owns an 8-bit configuration byte and a word-granular address register. The core sees both through a small register port: a 5-bit selector, write data, a write strobe and read data. The configuration bytes are grouped into wider registers, and the grouping follows the current machine register width, which can change at run time between 32 and 64 bits.

A width change never alters a stored configuration byte. It only changes which configuration register, and which byte lane, shows that byte. Address registers keep all their bits. At 32-bit width only their low 32 bits can be seen or written, and only those low bits take part in matching. The checker takes a physical byte address, an access kind and a privilege level. It reports, one cycle later, whether the access is allowed.

Top module: `pmp_unit`

## Requirements
- R1: After reset every configuration byte and address register reads as zero. With no entry enabled, a machine-mode access (priv 3) is allowed and any other privilege level is denied.
- R2: At 32-bit width (`mode64`=0), configuration register k (selector bit 4 = 0, k in bits 3:0) shows entry n in bits [8*(n%4)+7 : 8*(n%4)] when k = n/4. Write data bits 63:32 are ignored, and read data bits 63:32 are zero.
- R3: At 64-bit width, only even configuration registers hold bytes: entry n is in register 2*(n/8), at bits [8*(n%8)+7 : 8*(n%8)]. Odd registers read as zero, and writes to them change nothing.
- R4: Changing `mode64` keeps every configuration byte. For example, entry 4 is seen at bits [39:32] of register 0 at 64-bit width and at bits [7:0] of register 1 at 32-bit width.
- R5: Address register i has selector bit 4 = 1 and i in bits 3:0. At 32-bit width a read returns its low 32 bits zero-extended, and a write replaces only those 32 bits. The upper bits are kept and reappear at 64-bit width.
- R6: At 32-bit width, matching uses each address register's low 32 bits zero-extended, so higher stored bits have no effect on the decision.
- R7: Configuration byte layout: bit0 read, bit1 write, bit2 execute, bits 4:3 mode (0 off, 1 top-of-range, 2 single word, 3 aligned power of two), bit7 lock. Bits 6:5 always read zero. In top-of-range mode entry i matches word addresses (byte address >> 2) from address register i-1 (zero for entry 0) inclusive up to address register i exclusive.
- R8: Single-word mode matches when the word address equals the register. Power-of-two mode with t trailing ones in the register matches a naturally aligned region of 2^(t+3) bytes.
- R9: While an entry's lock bit is set, writes to its configuration byte and to its address register are ignored. Only reset clears a lock.
- R10: While entry i+1 is locked in top-of-range mode, writes to address register i are ignored.
- R11: An entry that matches and is not locked allows every machine-mode access. A locked entry applies its permissions to machine mode as well.
- R12: The lowest-numbered matching entry decides. If no entry matches, machine mode is allowed and lower privilege levels are denied.
- R13: Access kind (`chk_type`): 0 load needs read, 1 store and 3 atomic need write, 2 fetch needs execute.
- R14: `csr_rdata` and `chk_allow` are registered. Each reflects the inputs and the stored state of the previous clock edge, before that edge's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | 1 = 64-bit machine width, 0 = 32-bit |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 5 | Bit 4: 1 address file, 0 configuration; bits 3:0 index |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Registered read data for csr_addr |
| chk_addr | input | PA_W | Physical byte address to check |
| chk_type | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 atomic |
| chk_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| chk_allow | output | 1 | Registered permission result |

## Verification
The bench moves the same configuration byte between the two widths. A design that packed the bytes by register number rather than by entry would show entry 4 in the wrong lane, or would let an odd 64-bit register write entries. An address register is given bits above bit 31 and then checked in 32-bit mode. A design that did not zero-extend would miss the single-word match or keep a stale upper half after a narrow write. The bench also puts overlapping power-of-two regions side by side, locked entries and a locked top-of-range neighbour. A wrong priority, a machine-mode bypass that ignores the lock, or a missing guard on the address register below a locked entry would each show up as a flipped allow or a changed read value.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_AMO   = 2'd3
  } acc_e;

  localparam logic [1:0] PRIV_M = 2'd3;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    amode_e     mode;
    logic       x;
    logic       w;
    logic       r;
  } cfg_t;

  function automatic cfg_t cfg_from_byte(input logic [7:0] b);
    return cfg_t'({b[7], 2'b00, b[4:0]});
  endfunction
endpackage

// File: rtl/pmp_cfg_regs.sv
module pmp_cfg_regs
  import pmp_pkg::*;
#(
  parameter int N      = 16,
  parameter int CIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode64,
  input  logic              wr_en,
  input  logic [CIDX_W-1:0] idx,
  input  logic [63:0]       wdata,
  output cfg_t [N-1:0]      cfg_o,
  output logic [63:0]       rdata
);
  cfg_t [N-1:0] cfg_q;

  for (genvar n = 0; n < N; n++) begin : g_ent
    localparam int GRP32 = n / 4;
    localparam int LANE32 = n % 4;
    localparam int GRP64 = 2 * (n / 8);
    localparam int LANE64 = n % 8;

    logic       hit;
    logic [7:0] wbyte;

    always_comb begin
      hit   = mode64 ? (idx == CIDX_W'(GRP64)) : (idx == CIDX_W'(GRP32));
      wbyte = mode64 ? wdata[8*LANE64 +: 8] : wdata[8*LANE32 +: 8];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[n] <= cfg_t'(8'h00);
      end else if (wr_en && hit && !cfg_q[n].lock) begin
        cfg_q[n] <= cfg_from_byte(wbyte);
      end
    end

    // R9: a locked byte never changes until reset
    p_locked_cfg_stable_r9: assert property (@(posedge clk) disable iff (rst)
      cfg_q[n].lock |=> $stable(cfg_q[n]));
  end

  always_comb begin
    rdata = '0;
    for (int n = 0; n < N; n++) begin
      if (mode64 && idx == CIDX_W'(2 * (n / 8)))
        rdata[8*(n%8) +: 8] = cfg_q[n];
      else if (!mode64 && idx == CIDX_W'(n / 4))
        rdata[8*(n%4) +: 8] = cfg_q[n];
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/pmp_addr_regs.sv
module pmp_addr_regs
  import pmp_pkg::*;
#(
  parameter int N      = 16,
  parameter int AW     = 38,
  parameter int AIDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mode64,
  input  logic                 wr_en,
  input  logic [AIDX_W-1:0]    idx,
  input  logic [63:0]          wdata,
  input  cfg_t [N-1:0]         cfg_i,
  output logic [N-1:0][AW-1:0] eff_o,
  output logic [63:0]          rdata
);
  localparam int NARROW = 32;

  logic [N-1:0][AW-1:0] addr_q;
  logic [N-1:0]         guard;

  for (genvar i = 0; i < N; i++) begin : g_reg
    if (i + 1 < N) begin : g_nb
      assign guard[i] = cfg_i[i].lock |
                        (cfg_i[i+1].lock && cfg_i[i+1].mode == AM_TOR);
    end else begin : g_last
      assign guard[i] = cfg_i[i].lock;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[i] <= '0;
      end else if (wr_en && idx == AIDX_W'(i) && !guard[i]) begin
        if (mode64) addr_q[i] <= wdata[AW-1:0];
        else        addr_q[i][NARROW-1:0] <= wdata[NARROW-1:0];
      end
    end

    assign eff_o[i] = mode64 ? addr_q[i] : {{(AW-NARROW){1'b0}}, addr_q[i][NARROW-1:0]};

    // R9, R10: a guarded register holds its value
    p_locked_addr_stable_r10: assert property (@(posedge clk) disable iff (rst)
      guard[i] |=> $stable(addr_q[i]));
  end

  always_comb begin
    rdata = '0;
    if (int'(idx) < N) rdata = 64'(eff_o[idx]);
  end
endmodule

// File: rtl/pmp_match.sv
module pmp_match
  import pmp_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = 38
) (
  input  cfg_t [N-1:0]         cfg_i,
  input  logic [N-1:0][AW-1:0] eff_i,
  input  logic [AW-1:0]        word,
  input  logic [1:0]           acc,
  input  logic [1:0]           priv,
  output logic                 allow
);
  logic [N-1:0] hit;
  logic [N-1:0] perm;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic [AW-1:0] lo;
    logic [AW-1:0] span;

    if (i == 0) begin : g_base
      assign lo = '0;
    end else begin : g_prev
      assign lo = eff_i[i-1];
    end

    assign span = eff_i[i] ^ (eff_i[i] + AW'(1));

    always_comb begin
      unique case (cfg_i[i].mode)
        AM_TOR:   hit[i] = (word >= lo) && (word < eff_i[i]);
        AM_NA4:   hit[i] = (word == eff_i[i]);
        AM_NAPOT: hit[i] = ((word | span) == (eff_i[i] | span));
        default:  hit[i] = 1'b0;
      endcase
      unique case (acc_e'(acc))
        ACC_LOAD:  perm[i] = cfg_i[i].r;
        ACC_FETCH: perm[i] = cfg_i[i].x;
        default:   perm[i] = cfg_i[i].w;
      endcase
    end
  end

  always_comb begin
    allow = (priv == PRIV_M);
    for (int i = N - 1; i >= 0; i--) begin
      if (hit[i]) allow = (priv == PRIV_M && !cfg_i[i].lock) ? 1'b1 : perm[i];
    end
  end
endmodule

// File: rtl/pmp_unit.sv
module pmp_unit
  import pmp_pkg::*;
#(
  parameter int N    = 16,
  parameter int PA_W = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mode64,
  input  logic            csr_we,
  input  logic [4:0]      csr_addr,
  input  logic [63:0]     csr_wdata,
  output logic [63:0]     csr_rdata,
  input  logic [PA_W-1:0] chk_addr,
  input  logic [1:0]      chk_type,
  input  logic [1:0]      chk_priv,
  output logic            chk_allow
);
  localparam int AW    = PA_W - 2;
  localparam int IDX_W = 4;

  cfg_t [N-1:0]         cfg;
  logic [N-1:0][AW-1:0] eff;
  logic [63:0]          cfg_rd;
  logic [63:0]          addr_rd;
  logic                 allow_c;
  logic [N-1:0]         locks;

  pmp_cfg_regs #(.N(N), .CIDX_W(IDX_W)) u_cfg (
    .clk(clk), .rst(rst), .mode64(mode64),
    .wr_en(csr_we && !csr_addr[4]), .idx(csr_addr[IDX_W-1:0]),
    .wdata(csr_wdata), .cfg_o(cfg), .rdata(cfg_rd)
  );

  pmp_addr_regs #(.N(N), .AW(AW), .AIDX_W(IDX_W)) u_addr (
    .clk(clk), .rst(rst), .mode64(mode64),
    .wr_en(csr_we && csr_addr[4]), .idx(csr_addr[IDX_W-1:0]),
    .wdata(csr_wdata), .cfg_i(cfg), .eff_o(eff), .rdata(addr_rd)
  );

  pmp_match #(.N(N), .AW(AW)) u_match (
    .cfg_i(cfg), .eff_i(eff), .word(chk_addr[PA_W-1:2]),
    .acc(chk_type), .priv(chk_priv), .allow(allow_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_rdata <= '0;
      chk_allow <= 1'b0;
    end else begin
      csr_rdata <= csr_addr[4] ? addr_rd : cfg_rd;
      chk_allow <= allow_c;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_lk
    assign locks[i] = cfg[i].lock;
  end

  p_rdata_hi_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !mode64 |=> csr_rdata[63:32] == 32'd0);

  p_odd_cfg_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (mode64 && !csr_addr[4] && csr_addr[0]) |=> csr_rdata == 64'd0);

  p_m_unlocked_allow_r11: assert property (@(posedge clk) disable iff (rst)
    (chk_priv == PRIV_M && locks == '0) |=> chk_allow);
endmodule

// File: tb/pmp_unit_test.sv
module pmp_unit_test;
  localparam int CLK_NS = 10;
  localparam int PA_W = 40;

  logic clk = 0, rst = 1, mode64 = 0, csr_we = 0;
  logic [4:0] csr_addr = 0;
  logic [63:0] csr_wdata = 0, csr_rdata;
  logic [PA_W-1:0] chk_addr = 0;
  logic [1:0] chk_type = 0, chk_priv = 0;
  logic chk_allow;

  int vec = 0, bad = 0;
  logic [7:0]  mcfg [16];
  logic [37:0] madr [16];

  always #(CLK_NS/2) clk = ~clk;

  pmp_unit #(.N(16), .PA_W(PA_W)) uut (.*);

  function automatic logic [63:0] exp_read(input logic [4:0] ca, input logic m64);
    logic [63:0] r = 0;
    if (ca[4]) begin
      r = m64 ? 64'(madr[ca[3:0]]) : 64'(madr[ca[3:0]][31:0]);
    end else begin
      for (int n = 0; n < 16; n++) begin
        if (m64 && ca[3:0] == 4'(2*(n/8))) r[8*(n%8) +: 8] = mcfg[n];
        if (!m64 && ca[3:0] == 4'(n/4)) r[8*(n%4) +: 8] = mcfg[n];
      end
    end
    return r;
  endfunction

  function automatic logic exp_allow(input logic [39:0] a, input logic [1:0] t,
                                     input logic [1:0] p, input logic m64);
    logic [37:0] w = a[39:2];
    for (int n = 0; n < 16; n++) begin
      logic [37:0] hi = m64 ? madr[n] : 38'(madr[n][31:0]);
      logic [37:0] lo = (n == 0) ? 38'd0 : (m64 ? madr[n-1] : 38'(madr[n-1][31:0]));
      logic m = 0;
      case (mcfg[n][4:3])
        2'd1: m = (w >= lo) && (w < hi);
        2'd2: m = (w == hi);
        2'd3: begin
          int tz = 0;
          while (tz < 38 && hi[tz]) tz++;
          m = ((w >> (tz + 1)) == (hi >> (tz + 1)));
        end
        default: m = 0;
      endcase
      if (m) begin
        if (p == 2'd3 && !mcfg[n][7]) return 1'b1;
        if (t == 2'd0) return mcfg[n][0];
        if (t == 2'd2) return mcfg[n][2];
        return mcfg[n][1];
      end
    end
    return p == 2'd3;
  endfunction

  task automatic model_write(input logic [4:0] ca, input logic [63:0] wd, input logic m64);
    if (ca[4]) begin
      int i = int'(ca[3:0]);
      logic g = mcfg[i][7] || (i < 15 && mcfg[i+1][7] && mcfg[i+1][4:3] == 2'd1);
      if (!g) begin
        if (m64) madr[i] = wd[37:0];
        else madr[i][31:0] = wd[31:0];
      end
    end else begin
      for (int n = 0; n < 16; n++) begin
        logic [7:0] b;
        logic s;
        s = m64 ? (ca[3:0] == 4'(2*(n/8))) : (ca[3:0] == 4'(n/4));
        b = m64 ? wd[8*(n%8) +: 8] : wd[8*(n%4) +: 8];
        if (s && !mcfg[n][7]) mcfg[n] = b & 8'h9F;
      end
    end
  endtask

  task automatic step(input logic m64, input logic [4:0] ca, input logic we,
                      input logic [63:0] wd, input logic [39:0] a,
                      input logic [1:0] t, input logic [1:0] p, input string tag);
    logic [63:0] er;
    logic ea;
    mode64 = m64; csr_addr = ca; csr_we = we; csr_wdata = wd;
    chk_addr = a; chk_type = t; chk_priv = p;
    er = exp_read(ca, m64);
    ea = exp_allow(a, t, p, m64);
    @(posedge clk);
    if (we) model_write(ca, wd, m64);
    @(negedge clk);
    vec += 2;
    if (csr_rdata !== er) begin
      bad++;
      $display("FAIL %s rdata: actual %h expected %h", tag, csr_rdata, er);
    end
    if (chk_allow !== ea) begin
      bad++;
      $display("FAIL %s allow: actual %b expected %b", tag, chk_allow, ea);
    end
  endtask

  initial begin
    #(CLK_NS * 100000);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    for (int n = 0; n < 16; n++) begin mcfg[n] = 0; madr[n] = 0; end
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    step(1, 5'h00, 0, 0, 40'h100, 0, 0, "R1");
    step(1, 5'h10, 0, 0, 40'h100, 0, 3, "R1");
    // R3, R4 64-bit packing, entry 4 lane
    step(1, 5'h00, 1, 64'h0000_000F_0000_0000, 0, 0, 1, "R3");
    step(1, 5'h00, 0, 0, 0, 0, 3, "R3");
    step(1, 5'h01, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R3");
    step(1, 5'h01, 0, 0, 0, 0, 0, "R3");
    step(0, 5'h01, 0, 0, 0, 0, 0, "R4");
    // R2 32-bit packing, upper half ignored
    step(0, 5'h00, 1, 64'hFFFF_FFFF_0000_0000, 0, 0, 0, "R2");
    step(0, 5'h01, 0, 0, 0, 0, 0, "R2");
    step(1, 5'h00, 0, 0, 0, 0, 0, "R4");
    // R5 address width
    step(1, 5'h10, 1, 64'h3F_0000_0010, 0, 0, 0, "R5");
    step(1, 5'h10, 0, 0, 0, 0, 0, "R5");
    step(0, 5'h10, 0, 0, 0, 0, 0, "R5");
    step(0, 5'h10, 1, 64'hFFFF_FFFF_0000_0020, 0, 0, 0, "R5");
    step(1, 5'h10, 0, 0, 0, 0, 0, "R5");
    // R7 TOR for entry 4 over [0x100,0x200) words
    step(1, 5'h13, 1, 64'h100, 0, 0, 0, "R7");
    step(1, 5'h14, 1, 64'h200, 40'h400, 0, 1, "R7");
    step(1, 5'h14, 0, 0, 40'h400, 0, 1, "R7");
    step(1, 5'h14, 0, 0, 40'h3FC, 0, 1, "R7");
    step(1, 5'h14, 0, 0, 40'h7FC, 0, 0, "R7");
    step(1, 5'h14, 0, 0, 40'h800, 0, 0, "R7");
    // R6, R8 NA4 entry 8 with a bit above 31, NAPOT entries 9, 10
    step(1, 5'h18, 1, 64'h1_0000_0040, 0, 0, 0, "R6");
    step(1, 5'h19, 1, 64'h1003, 0, 0, 0, "R8");
    step(1, 5'h1A, 1, 64'h1007, 0, 0, 0, "R8");
    step(0, 5'h02, 1, 64'h0000_0000_001F_1C11, 0, 0, 0, "R7");
    step(0, 5'h02, 0, 0, 40'h100, 0, 0, "R6");
    step(1, 5'h02, 0, 0, 40'h100, 0, 0, "R6");
    step(1, 5'h02, 0, 0, 40'h4_0000_0100, 0, 0, "R6");
    step(0, 5'h02, 0, 0, 40'h4_0000_0100, 0, 0, "R6");
    step(0, 5'h00, 0, 0, 40'h401C, 2, 0, "R8");
    step(0, 5'h00, 0, 0, 40'h4020, 2, 0, "R8");
    // R12 priority, R13 access kinds
    step(0, 5'h00, 0, 0, 40'h4000, 0, 0, "R12");
    step(0, 5'h00, 0, 0, 40'h4020, 0, 0, "R12");
    step(0, 5'h00, 0, 0, 40'h4020, 3, 1, "R13");
    step(0, 5'h00, 0, 0, 40'h100, 3, 1, "R13");
    step(0, 5'h00, 0, 0, 40'h100, 1, 0, "R13");
    step(0, 5'h00, 0, 0, 40'h8000_0000, 0, 3, "R12");
    step(0, 5'h00, 0, 0, 40'h8000_0000, 0, 0, "R12");
    // R11 machine mode and lock
    step(0, 5'h00, 0, 0, 40'h100, 1, 3, "R11");
    step(0, 5'h02, 1, 64'h0000_0000_001F_1C91, 0, 0, 0, "R11");
    step(0, 5'h02, 0, 0, 40'h100, 1, 3, "R11");
    step(0, 5'h02, 0, 0, 40'h100, 0, 3, "R11");
    // R9 lock ignores writes; reserved bits read zero
    step(0, 5'h02, 1, 64'h6000_0000, 0, 0, 0, "R9");
    step(0, 5'h02, 0, 0, 0, 0, 0, "R9");
    step(1, 5'h18, 1, 64'h77, 0, 0, 0, "R9");
    step(1, 5'h18, 0, 0, 0, 0, 0, "R9");
    // R10 locked TOR neighbour guards address register below
    step(0, 5'h03, 1, 64'h89, 0, 0, 0, "R10");
    step(1, 5'h1B, 1, 64'h555, 0, 0, 0, "R10");
    step(1, 5'h1B, 0, 0, 0, 0, 0, "R10");
    step(1, 5'h1D, 1, 64'h666, 0, 0, 0, "R10");
    step(1, 5'h1D, 0, 0, 0, 0, 0, "R10");
    step(1, 5'h00, 0, 0, 0, 0, 0, "R14");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule